// File: doc/BRIEF.md
# Serial Digit Receiver with Seven-Segment Output

This block takes one asynchronous serial line carrying 8-N-1 characters (one start bit, eight data bits sent least significant bit first, one stop bit, no parity) and turns received ASCII decimal digits into a seven-segment display pattern. The line is brought into the clock domain through a two-flop synchroniser. A falling edge on the idle-high line starts a frame, and every bit is then sampled near its centre.

The bit period in clocks is derived from the clock and baud-rate parameters. At the defaults of 33 MHz and 9600 baud it is 3437 clocks. The receiver first waits half a bit period to reach the centre of the start bit, then waits one full bit period before each following sample.

A correctly framed byte raises a single-cycle valid strobe. If that byte is the ASCII code of a digit, the segment output is updated at the same edge. Any other byte, and any byte whose stop bit is low, leaves the display as it was.

Top module: `uart_digit_display`

## Requirements
- R1: While rst_ni is low and after its release, seg_o is 7'b1111111 (all segments dark) and valid_o is 0 until the first good byte.
- R2: The line rx_i passes through a two-flop synchroniser, and a frame starts only on a high-to-low transition seen while the receiver is idle.
- R3: The start bit is re-sampled half a bit period after the detected edge. If the line is high there, the event is discarded as a glitch and the receiver returns to idle, so a low pulse shorter than half a bit yields no strobe and the next character is received normally.
- R4: Data bits are sampled one full bit period apart, starting one bit period after the start-bit centre. The first sampled bit is data bit 0.
- R5: The stop bit is sampled one bit period after data bit 7. If it reads low, the byte is dropped: no strobe is raised and seg_o is unchanged.
- R6: Every byte with a high stop bit, digit or not, produces a valid_o pulse exactly one clock wide. seg_o changes only in a cycle where valid_o is high.
- R7: Bytes 8'h30 to 8'h39 ('0' to '9') set seg_o, as bits [6:0], to 0000001, 0111101, 0010010, 0011000, 0101100, 1001000, 1000000, 0011101, 0000000 and 0001000 in that order. A 0 lights a segment.
- R8: A well-framed byte outside 8'h30 to 8'h39 leaves seg_o unchanged.
- R9: The bit period is CLK_HZ/BAUD clocks, rounded down (3437 at the defaults), and the half period is that value divided by two, rounded down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| seg_o | output | 7 | Segment pattern, active low |
| valid_o | output | 1 | One-cycle strobe per well-framed byte |

## Verification
The hardest case to reach from the ports is the false-start path. For it, the line has to drop and recover before the start-bit centre, which is late enough for the synchroniser and edge detector to see the drop but early enough that the centre sample reads high. The bench drives a low pulse a few clocks long, shorter than half of its reduced 16-clock bit period. It then confirms that no strobe appears and that a real character sent straight afterwards is still decoded. Framing errors are produced by a frame builder whose stop-bit level is a field of each stimulus vector. Reset in the middle of a frame is also driven.

// File: rtl/uart_digit_pkg.sv
package uart_digit_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam logic [6:0] SEG_BLANK = 7'b1111111;

  function automatic logic is_digit(input logic [7:0] b);
    return (b >= 8'h30) && (b <= 8'h39);
  endfunction

  // active-low pattern for a digit value 0..9
  function automatic logic [6:0] digit_seg(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0:    s = 7'b0000001;
      4'd1:    s = 7'b0111101;
      4'd2:    s = 7'b0010010;
      4'd3:    s = 7'b0011000;
      4'd4:    s = 7'b0101100;
      4'd5:    s = 7'b1001000;
      4'd6:    s = 7'b1000000;
      4'd7:    s = 7'b0011101;
      4'd8:    s = 7'b0000000;
      4'd9:    s = 7'b0001000;
      default: s = SEG_BLANK;
    endcase
    return s;
  endfunction

  function automatic logic seg_legal(input logic [6:0] s);
    logic ok;
    ok = (s == SEG_BLANK);
    for (int i = 0; i < 10; i++) begin
      if (s == digit_seg(4'(i))) ok = 1'b1;
    end
    return ok;
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], rx_i};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign rx_s_o = sr_q[STAGES-1];
  assign fall_o = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_digit_pkg::*;
#(
  parameter int BIT_CYC = 3437,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_s_i,
  input  logic              fall_i,
  output logic              stb_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_ph_o
);
  localparam int HALF_CYC = BIT_CYC / 2;
  localparam int CNT_W    = $clog2(BIT_CYC + 1);
  localparam int IDX_W    = $clog2(DATA_W);

  rx_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              stb_q;
  logic              tick;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (fall_i) begin
            cnt_q <= CNT_W'(HALF_CYC - 1);
            st_q  <= RX_START;
          end
        end
        RX_START: begin
          if (!tick) cnt_q <= cnt_q - 1'b1;
          else if (!rx_s_i) begin
            cnt_q <= CNT_W'(BIT_CYC - 1);
            idx_q <= '0;
            st_q  <= RX_DATA;
          end else st_q <= RX_IDLE;  // false start
        end
        RX_DATA: begin
          if (!tick) cnt_q <= cnt_q - 1'b1;
          else begin
            sh_q  <= {rx_s_i, sh_q[DATA_W-1:1]};  // lsb first
            cnt_q <= CNT_W'(BIT_CYC - 1);
            if (idx_q == IDX_W'(DATA_W - 1)) st_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (!tick) cnt_q <= cnt_q - 1'b1;
          else begin
            stb_q <= rx_s_i;  // low stop bit drops the byte
            st_q  <= RX_IDLE;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign stb_o     = stb_q;
  assign data_o    = sh_q;
  assign stop_ph_o = (st_q == RX_STOP) & tick;
endmodule

// File: rtl/seg_latch.sv
module seg_latch
  import uart_digit_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stb_i,
  input  logic [7:0] data_i,
  output logic [6:0] seg_o,
  output logic       valid_o
);
  logic [6:0] seg_q;
  logic       vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_BLANK;
      vld_q <= 1'b0;
    end else begin
      vld_q <= stb_i;
      if (stb_i && is_digit(data_i)) seg_q <= digit_seg(data_i[3:0]);
    end
  end

  assign seg_o   = seg_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/uart_digit_display.sv
module uart_digit_display #(
  parameter int CLK_HZ = 33_000_000,
  parameter int BAUD   = 9600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  output logic [6:0] seg_o,
  output logic       valid_o
);
  localparam int BIT_CYC = CLK_HZ / BAUD;

  logic       rx_s, fall, byte_stb, stop_ph;
  logic [7:0] byte_d;

  rx_line_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .rx_s_o(rx_s),
    .fall_o(fall)
  );

  rx_frame_fsm #(.BIT_CYC(BIT_CYC), .DATA_W(8)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_s_i   (rx_s),
    .fall_i   (fall),
    .stb_o    (byte_stb),
    .data_o   (byte_d),
    .stop_ph_o(stop_ph)
  );

  seg_latch u_seg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (byte_stb),
    .data_i (byte_d),
    .seg_o  (seg_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/uart_digit_display_chk.sv
module uart_digit_display_chk
  import uart_digit_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [6:0] seg_i,
  input logic       stb_i,
  input logic       stop_ph_i
);
  p_valid_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_seg_moves_with_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_i) |-> valid_i);

  p_seg_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_legal(seg_i));

  p_valid_follows_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $past(stb_i));

  p_stb_from_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |-> $past(stop_ph_i));
endmodule

bind uart_digit_display uart_digit_display_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_o),
  .seg_i    (seg_o),
  .stb_i    (byte_stb),
  .stop_ph_i(stop_ph)
);

// File: tb/uart_digit_display_tb_top.sv
`timescale 1ns/1ps
module uart_digit_display_tb_top;
  localparam int CLK_HZ = 160;
  localparam int BAUD   = 10;
  localparam int BIT    = CLK_HZ / BAUD;  // 16
  localparam int NVEC   = 16;

  // {stop_level, byte}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 8'h30}, {1'b1, 8'h31}, {1'b1, 8'h32}, {1'b1, 8'h33},
    {1'b1, 8'h34}, {1'b1, 8'h35}, {1'b1, 8'h36}, {1'b1, 8'h37},
    {1'b1, 8'h38}, {1'b1, 8'h39}, {1'b1, 8'h41}, {1'b1, 8'h2F},
    {1'b0, 8'h32}, {1'b1, 8'h3A}, {1'b1, 8'h35}, {1'b1, 8'hB5}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [6:0] seg_o;
  logic       valid_o;

  int total = 0;
  int bad   = 0;
  int vcnt  = 0;
  int wide  = 0;
  logic vprev = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_digit_display #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .seg_o  (seg_o),
    .valid_o(valid_o)
  );

  always @(negedge clk_i) begin
    if (valid_o) vcnt++;
    if (valid_o && vprev) wide++;
    vprev = valid_o;
  end

  function automatic logic [6:0] want_seg(input logic [7:0] b, input logic [6:0] old);
    case (b)
      8'h30: return 7'b0000001;
      8'h31: return 7'b0111101;
      8'h32: return 7'b0010010;
      8'h33: return 7'b0011000;
      8'h34: return 7'b0101100;
      8'h35: return 7'b1001000;
      8'h36: return 7'b1000000;
      8'h37: return 7'b0011101;
      8'h38: return 7'b0000000;
      8'h39: return 7'b0001000;
      default: return old;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    rx_i = 1'b0;
    repeat (BIT) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (BIT) @(negedge clk_i);
    end
    rx_i = stop;
    repeat (BIT) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (3 * BIT) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [6:0] exp_seg;
    repeat (4) @(negedge clk_i);
    check("R1 seg in reset", seg_o, 7'h7F);
    check("R1 valid in reset", valid_o, 0);
    rst_ni = 1'b1;
    repeat (2 * BIT) @(negedge clk_i);
    check("R1 seg after reset", seg_o, 7'h7F);
    check("R1 no valid after reset", vcnt, 0);

    // vector walk: R2 R4 R5 R7 R8 R9
    exp_seg = 7'h7F;
    for (int v = 0; v < NVEC; v++) begin
      vcnt = 0;
      send(VEC[v][7:0], VEC[v][8]);
      if (VEC[v][8]) exp_seg = want_seg(VEC[v][7:0], exp_seg);
      check($sformatf("R5/R6 strobe count vec %0d", v), vcnt, VEC[v][8] ? 1 : 0);
      check($sformatf("R4/R7/R8/R9 seg vec %0d", v), seg_o, exp_seg);
    end
    check("R6 valid width one cycle", wide, 0);

    // R3: short low glitch, then a real char
    vcnt = 0;
    rx_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (2 * BIT) @(negedge clk_i);
    check("R3 glitch gives no strobe", vcnt, 0);
    check("R3 glitch leaves seg", seg_o, exp_seg);
    send(8'h37, 1'b1);
    check("R3 char after glitch strobe", vcnt, 1);
    check("R3 char after glitch seg", seg_o, 7'b0011101);

    // R2: line held low (no fresh edge) after a framing error gives nothing more
    vcnt = 0;
    rx_i = 1'b0;
    repeat (14 * BIT) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (3 * BIT) @(negedge clk_i);
    check("R2 held-low line strobe", vcnt, 0);
    check("R2 held-low line seg", seg_o, 7'b0011101);

    // R1: reset in the middle of a frame
    rx_i = 1'b0;
    repeat (4 * BIT) @(negedge clk_i);
    rst_ni = 1'b0;
    rx_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 mid-frame reset seg", seg_o, 7'h7F);
    check("R1 mid-frame reset valid", valid_o, 0);
    rst_ni = 1'b1;
    repeat (2 * BIT) @(negedge clk_i);
    vcnt = 0;
    send(8'h30, 1'b1);
    check("R1 recovery strobe", vcnt, 1);
    check("R7 recovery seg zero", seg_o, 7'b0000001);
    check("R6 final width check", wide, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule